// File: doc/BRIEF.md
# Filtered Event Counter Bank

This block is a small bank of event counters for an accelerator device. It sits behind a simple register port. The event sources deliver one strobe per cycle, and each strobe carries a category, an encoding and five attribute indices: work queue, traffic class, page size, transfer size and engine. Each counter has its own configuration word, which selects a category and an encoding and holds an enable bit and an interrupt-on-overflow bit. Each counter also has five filter masks. A strobe advances a counter only when the category and encoding both match, the counter is enabled, the bank is not frozen, and every non-zero filter mask shares a bit with the one-hot form of the matching attribute.

Shared registers give software the rest of its control. A read-only capability word describes the bank. A reset command register clears either the configuration or the counter data. A freeze register holds every counter at once. A write-1-to-clear overflow status word latches counter wrap-arounds. The interrupt output is a level, and it stays high while any latched overflow belongs to a counter whose interrupt-on-overflow bit is set.

Software reads counter data as a 64-bit value. It computes event counts as differences modulo the counter width.

Top module: `evt_counter_bank`

## Requirements
- R1: After reset, every counter reads zero, the overflow status reads zero, the freeze register reads zero and `irq` is low.
- R2: The capability word is at address 0x00 and is read-only. Its fields are:
  - bits [7:0]: the counter count.
  - bits [15:8]: the counter width.
  - bit 16: 1, an overflow interrupt exists.
  - bit 17: 1, freeze exists.
  - bits [23:20]: the number of categories.
  - bits [47:32]: the supported-category bitmap.
  - bits [52:48]: the supported-filter bitmap, 5'h1F.
  - bit 56: 0, no per-counter capability.
  - All other bits are zero.
- R3: The configuration word of counter n is at 0x10+n. Its fields are:
  - bit 0: enable.
  - bit 1: interrupt on overflow.
  - bits [7:4]: category.
  - bits [23:8]: encoding.
  - Bits [3:2] and [31:24] read as zero.
  - A counter advances by one on a strobe only while it is enabled and `evt_cat` and `evt_enc` both equal its fields.
- R4: The filter f of counter n is at 0x40+8n+f. The filters, with the bits they keep, are:
  - f=0: work queue, 32 bits.
  - f=1: traffic class, 8 bits.
  - f=2: page size, 4 bits.
  - f=3: transfer size, 8 bits.
  - f=4: engine, 8 bits.
  - A zero filter does not restrict counting.
  - A non-zero filter passes a strobe only if its bit at the strobe's attribute index is set.
- R5: Writing 1 in bit 0 at address 0x02 freezes all counters, and writing 0 there releases them. While the bank is frozen, counter values hold and stay readable.
- R6: The reset register at 0x01 takes two commands:
  - Bit 0 clears all configuration words, all filters, the freeze bit and the overflow status.
  - Bit 1 zeroes all counter data, and an increment or wrap in that same cycle is dropped.
- R7: A counter wraps modulo 2^width. At the wrap it reads zero and sets bit n of the overflow status at 0x03.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A wrap in the same cycle as a clearing write leaves the bit set.
- R9: `irq` is high exactly while some status bit is set whose counter has interrupt-on-overflow set.
- R10: Counter data is at 0x20+n and reads as a 64-bit value with zeros above the counter width. Writes to the capability and counter data addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 64 | Register read data, combinational |
| evt_valid | input | 1 | Event strobe |
| evt_cat | input | 4 | Event category |
| evt_enc | input | 16 | Event encoding |
| evt_wq | input | 5 | Work queue index |
| evt_tc | input | 3 | Traffic class index |
| evt_pgsz | input | 2 | Page size index |
| evt_xfer | input | 3 | Transfer size index |
| evt_eng | input | 3 | Engine index |
| irq | output | 1 | Level overflow interrupt |

## Verification
The assertions assume one register write per cycle, and at most one event strobe per cycle. They also assume that the reset register is written only to issue commands. The interrupt property requires that no register write lands in the same cycle as the wrap. This keeps a configuration change from legally masking the interrupt in that cycle. The stimulus issues writes and strobes in separate cycles, and in every case where a property relies on that gap the scenarios leave the write port idle while the event strobes run.

// File: rtl/evb_pkg.sv
// Shared definitions for the filtered event counter bank: register addresses,
// the per-counter configuration layout, filter indices and filter widths.
// Assumes an 8-bit word address space and 32-bit register writes.
package evb_pkg;

    localparam int ADDR_W      = 8;
    localparam int NUM_FLT     = 5;

    localparam int F_WQ        = 0;
    localparam int F_TC        = 1;
    localparam int F_PG        = 2;
    localparam int F_XS        = 3;
    localparam int F_ENG       = 4;

    localparam int A_CAP       = 'h00;
    localparam int A_RST       = 'h01;
    localparam int A_FRZ       = 'h02;
    localparam int A_OVF       = 'h03;
    localparam int A_CFG_BASE  = 'h10;
    localparam int A_DATA_BASE = 'h20;
    localparam int A_FLT_BASE  = 'h40;
    localparam int FLT_STRIDE  = 8;

    localparam int RST_CFG_BIT = 0;
    localparam int RST_CNT_BIT = 1;

    // Counter configuration word, LSB first: en, irq_en, 2 reserved, cat, enc
    typedef struct packed {
        logic [15:0] enc;
        logic [3:0]  cat;
        logic [1:0]  rsvd;
        logic        irq_en;
        logic        en;
    } cnt_cfg_t;

    // Mask of implemented bits for each filter type
    function automatic logic [31:0] flt_mask(input int f);
        case (f)
            F_WQ:    return 32'hFFFF_FFFF;
            F_PG:    return 32'h0000_000F;
            default: return 32'h0000_00FF;
        endcase
    endfunction

endpackage

// File: rtl/evb_filter_match.sv
// Filter qualification for one counter. Each filter is a mask compared with
// the one-hot form of the event attribute; a zero mask passes everything.
// Assumes one-hot attribute vectors are already decoded by the caller.
module evb_filter_match
    import evb_pkg::*;
(
    input  logic [NUM_FLT-1:0][31:0] flt,
    input  logic [NUM_FLT-1:0][31:0] evt_oh,
    output logic                     pass
);

    logic [NUM_FLT-1:0] ok;

    for (genvar f = 0; f < NUM_FLT; f++) begin : g_flt
        // One filter passes when unused or when it shares a bit with the event
        assign ok[f] = (flt[f] == '0) || ((flt[f] & evt_oh[f]) != '0);
    end

    assign pass = &ok;

endmodule

// File: rtl/evb_counter.sv
// One counter slice: configuration word, five filter masks and the count.
// Counts a qualified strobe per cycle, wraps modulo 2^CNT_W and reports the
// wrap as a one-cycle ovf pulse. Assumes clr_cfg and clr_cnt come from
// the shared reset register and frozen from the shared freeze register.
module evb_counter
    import evb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_cfg,
    input  logic                     clr_cnt,
    input  logic                     frozen,
    input  logic                     cfg_we,
    input  logic [NUM_FLT-1:0]       flt_we,
    input  logic [31:0]              wr_data,
    input  logic                     evt_valid,
    input  logic [3:0]               evt_cat,
    input  logic [15:0]              evt_enc,
    input  logic [NUM_FLT-1:0][31:0] evt_oh,
    output cnt_cfg_t                 cfg,
    output logic [NUM_FLT-1:0][31:0] flt,
    output logic [CNT_W-1:0]         data,
    output logic                     ovf
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic flt_pass;
    logic hit;

    evb_filter_match u_match (
        .flt    (flt),
        .evt_oh (evt_oh),
        .pass   (flt_pass)
    );

    // Qualification: enabled, running, category/encoding match, filters pass
    assign hit = evt_valid && cfg.en && !frozen &&
                 (evt_cat == cfg.cat) && (evt_enc == cfg.enc) && flt_pass;
    assign ovf = hit && (data == CNT_MAX) && !clr_cnt;

    // Configuration register with reserved bits forced to zero
    always_ff @(posedge clk) begin
        if (!rst_n || clr_cfg)
            cfg <= '0;
        else if (cfg_we)
            cfg <= cnt_cfg_t'({wr_data[23:4], 2'b00, wr_data[1:0]});
    end

    // Filter mask registers, trimmed to each filter's implemented width
    always_ff @(posedge clk) begin
        if (!rst_n || clr_cfg) begin
            flt <= '0;
        end else begin
            for (int f = 0; f < NUM_FLT; f++)
                if (flt_we[f])
                    flt[f] <= wr_data & flt_mask(f);
        end
    end

    // Counter data: cleared by command, otherwise advances on a hit
    always_ff @(posedge clk) begin
        if (!rst_n || clr_cnt)
            data <= '0;
        else if (hit)
            data <= data + 1'b1;
    end

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        frozen && !clr_cnt |=> $stable(data)); // R5
    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en && !clr_cnt |=> $stable(data)); // R3
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (data == '0)); // R7
    AST_CFG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cfg |=> (cfg == '0) && (flt == '0)); // R6

endmodule

// File: rtl/evt_counter_bank.sv
// Filtered event counter bank top: register decode, shared reset, freeze and
// overflow status registers, capability word, read mux and level interrupt.
// Assumes at most one register write and one event strobe per cycle; reads
// are combinational from rd_addr.
module evt_counter_bank
    import evb_pkg::*;
#(
    parameter int          NUM_CNT = 4,
    parameter int          CNT_W   = 16,
    parameter int          NUM_CAT = 4,
    parameter logic [15:0] CAT_MAP = 16'h000F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [63:0]       rd_data,
    input  logic              evt_valid,
    input  logic [3:0]        evt_cat,
    input  logic [15:0]       evt_enc,
    input  logic [4:0]        evt_wq,
    input  logic [2:0]        evt_tc,
    input  logic [1:0]        evt_pgsz,
    input  logic [2:0]        evt_xfer,
    input  logic [2:0]        evt_eng,
    output logic              irq
);

    localparam logic [63:0] CAP_WORD =
        64'(NUM_CNT) | (64'(CNT_W) << 8) | (64'd1 << 16) | (64'd1 << 17) |
        (64'(NUM_CAT) << 20) | (64'(CAT_MAP) << 32) |
        (64'((1 << NUM_FLT) - 1) << 48);

    logic                     clr_cfg;
    logic                     clr_cnt;
    logic                     frozen;
    logic [NUM_CNT-1:0]       ovf_stat;
    logic [NUM_CNT-1:0]       ovf_vec;
    logic [NUM_CNT-1:0]       ien_vec;
    logic [NUM_CNT-1:0]       w1c;
    logic [NUM_FLT-1:0][31:0] evt_oh;
    cnt_cfg_t                 cfg_q  [NUM_CNT];
    logic [NUM_FLT-1:0][31:0] flt_q  [NUM_CNT];
    logic [CNT_W-1:0]         data_q [NUM_CNT];

    // Reset commands decoded from a write to the reset register
    assign clr_cfg = wr_en && (wr_addr == ADDR_W'(A_RST)) && wr_data[RST_CFG_BIT];
    assign clr_cnt = wr_en && (wr_addr == ADDR_W'(A_RST)) && wr_data[RST_CNT_BIT];
    assign w1c     = (wr_en && (wr_addr == ADDR_W'(A_OVF))) ? wr_data[NUM_CNT-1:0] : '0;

    // Decode event attribute indices to one-hot vectors for mask matching
    always_comb begin
        evt_oh        = '0;
        evt_oh[F_WQ]  = 32'd1 << evt_wq;
        evt_oh[F_TC]  = 32'd1 << evt_tc;
        evt_oh[F_PG]  = 32'd1 << evt_pgsz;
        evt_oh[F_XS]  = 32'd1 << evt_xfer;
        evt_oh[F_ENG] = 32'd1 << evt_eng;
    end

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        logic               cfg_we;
        logic [NUM_FLT-1:0] flt_we;

        assign cfg_we = wr_en && (wr_addr == ADDR_W'(A_CFG_BASE + i));
        for (genvar f = 0; f < NUM_FLT; f++) begin : g_fwe
            assign flt_we[f] = wr_en && (wr_addr == ADDR_W'(A_FLT_BASE + i*FLT_STRIDE + f));
        end

        evb_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr_cfg   (clr_cfg),
            .clr_cnt   (clr_cnt),
            .frozen    (frozen),
            .cfg_we    (cfg_we),
            .flt_we    (flt_we),
            .wr_data   (wr_data),
            .evt_valid (evt_valid),
            .evt_cat   (evt_cat),
            .evt_enc   (evt_enc),
            .evt_oh    (evt_oh),
            .cfg       (cfg_q[i]),
            .flt       (flt_q[i]),
            .data      (data_q[i]),
            .ovf       (ovf_vec[i])
        );

        assign ien_vec[i] = cfg_q[i].irq_en;
    end

    // Global freeze bit: set or released by software, cleared by config reset
    always_ff @(posedge clk) begin
        if (!rst_n || clr_cfg)
            frozen <= 1'b0;
        else if (wr_en && (wr_addr == ADDR_W'(A_FRZ)))
            frozen <= wr_data[0];
    end

    // Overflow status: write-1-to-clear, a new wrap wins over the clear
    always_ff @(posedge clk) begin
        if (!rst_n || clr_cfg)
            ovf_stat <= '0;
        else
            ovf_stat <= (ovf_stat & ~w1c) | ovf_vec;
    end

    assign irq = |(ovf_stat & ien_vec);

    // Register read mux, counter data zero-extended to 64 bits
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(A_CAP))
            rd_data = CAP_WORD;
        else if (rd_addr == ADDR_W'(A_FRZ))
            rd_data = 64'(frozen);
        else if (rd_addr == ADDR_W'(A_OVF))
            rd_data = 64'(ovf_stat);
        for (int i = 0; i < NUM_CNT; i++) begin
            if (rd_addr == ADDR_W'(A_CFG_BASE + i))
                rd_data = 64'(cfg_q[i]);
            if (rd_addr == ADDR_W'(A_DATA_BASE + i))
                rd_data = 64'(data_q[i]);
            for (int f = 0; f < NUM_FLT; f++)
                if (rd_addr == ADDR_W'(A_FLT_BASE + i*FLT_STRIDE + f))
                    rd_data = 64'(flt_q[i][f]);
        end
    end

    AST_IRQ_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ((ovf_vec & ien_vec) != '0) && !wr_en |=> irq); // R9
    AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_addr == ADDR_W'(A_OVF)) |=>
        ((ovf_stat & $past(w1c & ~ovf_vec)) == '0)); // R8
    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((ovf_stat & $past(ovf_stat)) == $past(ovf_stat))); // R8
    AST_WRAP_SETS_STAT: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_vec != '0) && !clr_cfg |=> ((ovf_stat & $past(ovf_vec)) == $past(ovf_vec))); // R7

endmodule

// File: tb/evt_counter_bank_bench.sv
// Bench for the filtered event counter bank: a behavioural reference model
// advanced every clock and compared on rd_data and irq after every edge.
module evt_counter_bank_bench;

    localparam int NC = 4;
    localparam int CW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [63:0] rd_data;
    logic        evt_valid = 1'b0;
    logic [3:0]  evt_cat = '0;
    logic [15:0] evt_enc = '0;
    logic [4:0]  evt_wq = '0;
    logic [2:0]  evt_tc = '0;
    logic [1:0]  evt_pgsz = '0;
    logic [2:0]  evt_xfer = '0;
    logic [2:0]  evt_eng = '0;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // Reference model state
    logic [31:0]       m_cfg [NC];
    logic [31:0]       m_flt [NC][5];
    longint unsigned   m_data [NC];
    logic [NC-1:0]     m_stat;
    bit                m_frz;

    always #5 clk = ~clk;

    evt_counter_bank #(.NUM_CNT(NC), .CNT_W(CW)) u_evt_counter_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .evt_valid(evt_valid), .evt_cat(evt_cat), .evt_enc(evt_enc),
        .evt_wq(evt_wq), .evt_tc(evt_tc), .evt_pgsz(evt_pgsz),
        .evt_xfer(evt_xfer), .evt_eng(evt_eng), .irq(irq)
    );

    function automatic logic [31:0] fw(int f);
        if (f == 0) return 32'hFFFF_FFFF;
        if (f == 2) return 32'h0000_000F;
        return 32'h0000_00FF;
    endfunction

    function automatic logic [63:0] exp_read(logic [7:0] a);
        if (a == 8'h00)
            return 64'(NC) | (64'(CW) << 8) | (64'd1 << 16) | (64'd1 << 17) |
                   (64'd4 << 20) | (64'h000F << 32) | (64'h1F << 48);
        if (a == 8'h02) return 64'(m_frz);
        if (a == 8'h03) return 64'(m_stat);
        for (int i = 0; i < NC; i++) begin
            if (a == 8'(16 + i)) return 64'(m_cfg[i]);
            if (a == 8'(32 + i)) return m_data[i];
            for (int f = 0; f < 5; f++)
                if (a == 8'(64 + i*8 + f)) return 64'(m_flt[i][f]);
        end
        return 64'd0;
    endfunction

    function automatic bit exp_irq();
        bit r = 0;
        for (int i = 0; i < NC; i++)
            if (m_stat[i] && m_cfg[i][1]) r = 1;
        return r;
    endfunction

    // Advance the model by one clock using the currently driven inputs
    task automatic model_next();
        longint unsigned nd [NC];
        logic [NC-1:0] ovf = '0;
        logic [31:0] oh [5];
        bit ccfg = wr_en && wr_addr == 8'h01 && wr_data[0];
        bit ccnt = wr_en && wr_addr == 8'h01 && wr_data[1];
        longint unsigned maxv = (64'd1 << CW) - 1;
        oh[0] = 32'd1 << evt_wq;  oh[1] = 32'd1 << evt_tc; oh[2] = 32'd1 << evt_pgsz;
        oh[3] = 32'd1 << evt_xfer; oh[4] = 32'd1 << evt_eng;
        for (int i = 0; i < NC; i++) begin
            bit ok = evt_valid && m_cfg[i][0] && !m_frz &&
                     m_cfg[i][7:4] == evt_cat && m_cfg[i][23:8] == evt_enc;
            for (int f = 0; f < 5; f++)
                if (m_flt[i][f] != 0 && (m_flt[i][f] & oh[f]) == 0) ok = 0;
            nd[i] = m_data[i];
            if (ccnt) nd[i] = 0;
            else if (ok) begin
                if (m_data[i] == maxv) begin nd[i] = 0; ovf[i] = 1'b1; end
                else nd[i] = m_data[i] + 1;
            end
        end
        for (int i = 0; i < NC; i++) m_data[i] = nd[i];
        if (ccfg) begin
            m_stat = '0; m_frz = 0;
            for (int i = 0; i < NC; i++) begin
                m_cfg[i] = '0;
                for (int f = 0; f < 5; f++) m_flt[i][f] = '0;
            end
        end else begin
            logic [NC-1:0] clr = (wr_en && wr_addr == 8'h03) ? wr_data[NC-1:0] : '0;
            m_stat = (m_stat & ~clr) | ovf;
            if (wr_en && wr_addr == 8'h02) m_frz = wr_data[0];
            for (int i = 0; i < NC; i++) begin
                if (wr_en && wr_addr == 8'(16 + i)) m_cfg[i] = wr_data & 32'h00FF_FFF3;
                for (int f = 0; f < 5; f++)
                    if (wr_en && wr_addr == 8'(64 + i*8 + f)) m_flt[i][f] = wr_data & fw(f);
            end
        end
    endtask

    // One clock: update model, then compare read data and interrupt
    task automatic step(string tag);
        model_next();
        @(posedge clk);
        @(negedge clk);
        n_cmp++;
        if (rd_data !== exp_read(rd_addr)) begin
            n_bad++;
            $display("FAIL %s rd_data @%h got %h exp %h", tag, rd_addr, rd_data, exp_read(rd_addr));
        end
        n_cmp++;
        if (irq !== exp_irq()) begin
            n_bad++;
            $display("FAIL %s irq got %0b exp %0b", tag, irq, exp_irq());
        end
        wr_en = 0;
        evt_valid = 0;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d, string tag);
        wr_en = 1; wr_addr = a; wr_data = d;
        step(tag);
    endtask

    task automatic rd(logic [7:0] a, string tag);
        rd_addr = a;
        step(tag);
    endtask

    task automatic ev(logic [3:0] c, logic [15:0] e, logic [4:0] wq, logic [2:0] tc,
                      logic [1:0] pg, logic [2:0] xs, logic [2:0] en, string tag);
        evt_valid = 1; evt_cat = c; evt_enc = e; evt_wq = wq; evt_tc = tc;
        evt_pgsz = pg; evt_xfer = xs; evt_eng = en;
        step(tag);
    endtask

    // Named check of one expected register value written from a requirement
    task automatic expect_reg(logic [7:0] a, logic [63:0] exp, string tag);
        rd_addr = a;
        #1;
        n_cmp++;
        if (rd_data !== exp) begin
            n_bad++;
            $display("FAIL %s @%h got %h exp %h", tag, a, rd_data, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        m_stat = '0; m_frz = 0;
        for (int i = 0; i < NC; i++) begin
            m_cfg[i] = '0; m_data[i] = 0;
            for (int f = 0; f < 5; f++) m_flt[i][f] = '0;
        end
        repeat (3) @(posedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        rd(8'h03, "R1 status");
        expect_reg(8'h20, 64'd0, "R1 data0");
        expect_reg(8'h02, 64'd0, "R1 freeze");
        // R2 capability word, also read-only (R10)
        rd(8'h00, "R2 cap");
        expect_reg(8'h00, 64'h001F_000F_0043_0804, "R2 cap fields");
        wr(8'h00, 32'hFFFF_FFFF, "R10 cap write");
        expect_reg(8'h00, 64'h001F_000F_0043_0804, "R10 cap unchanged");

        // R3 category/encoding match on counter 0
        wr(8'h10, 32'hFF00_053D, "R3 cfg0");   // en, cat 3, enc 0x0005, rsvd dropped
        expect_reg(8'h10, 64'h0000_0531, "R3 cfg reserved zero");
        rd(8'h20, "R3 watch");
        for (int k = 0; k < 5; k++) ev(4'd3, 16'h0005, 0, 0, 0, 0, 0, "R3 match");
        ev(4'd2, 16'h0005, 0, 0, 0, 0, 0, "R3 wrong cat");
        ev(4'd3, 16'h0006, 0, 0, 0, 0, 0, "R3 wrong enc");
        expect_reg(8'h20, 64'd5, "R3 count five");
        wr(8'h20, 32'h0000_00AA, "R10 data write");
        expect_reg(8'h20, 64'd5, "R10 data unchanged");

        // R4 filters on counter 1
        wr(8'h11, 32'h0000_0721, "R4 cfg1");   // en, cat 2, enc 7
        wr(8'h48, 32'h0000_0010, "R4 wq filter");
        wr(8'h49, 32'hFFFF_FF06, "R4 tc filter");
        expect_reg(8'h49, 64'h06, "R4 tc width trim");
        rd(8'h21, "R4 watch");
        ev(4'd2, 16'h0007, 5'd4, 3'd1, 0, 0, 0, "R4 pass");
        ev(4'd2, 16'h0007, 5'd3, 3'd1, 0, 0, 0, "R4 wq block");
        ev(4'd2, 16'h0007, 5'd4, 3'd0, 0, 0, 0, "R4 tc block");
        ev(4'd2, 16'h0007, 5'd4, 3'd2, 2'd3, 3'd7, 3'd5, "R4 zero filters free");
        expect_reg(8'h21, 64'd2, "R4 count two");

        // R5 freeze
        wr(8'h02, 32'h1, "R5 freeze");
        rd(8'h20, "R5 watch");
        for (int k = 0; k < 3; k++) ev(4'd3, 16'h0005, 0, 0, 0, 0, 0, "R5 frozen");
        expect_reg(8'h20, 64'd5, "R5 held");
        wr(8'h02, 32'h0, "R5 release");
        ev(4'd3, 16'h0005, 0, 0, 0, 0, 0, "R5 running");
        expect_reg(8'h20, 64'd6, "R5 resumed");

        // R7 wrap with interrupt on counter 2, R9 level irq, R8 W1C
        wr(8'h12, 32'h0000_0113, "R7 cfg2");   // en, irq_en, cat 1, enc 1
        rd(8'h22, "R7 watch");
        for (int k = 0; k < 256; k++) ev(4'd1, 16'h0001, 0, 0, 0, 0, 0, "R7 run");
        expect_reg(8'h22, 64'd0, "R7 wrapped");
        expect_reg(8'h03, 64'h4, "R7 status bit");
        rd(8'h03, "R9 irq high");
        wr(8'h03, 32'h0000_000B, "R8 write zero to bit");
        expect_reg(8'h03, 64'h4, "R8 bit kept");
        // R8 same-cycle wrap wins: bring counter 2 to max then clear at the wrap
        for (int k = 0; k < 255; k++) ev(4'd1, 16'h0001, 0, 0, 0, 0, 0, "R8 fill");
        wr(8'h03, 32'h4, "R8 clear");
        expect_reg(8'h03, 64'h0, "R8 cleared");
        rd(8'h03, "R9 irq low");
        evt_valid = 1; evt_cat = 1; evt_enc = 1; wr_en = 1; wr_addr = 8'h03; wr_data = 32'h4;
        step("R8 wrap and clear");
        expect_reg(8'h03, 64'h4, "R8 wrap wins");

        // R9 wrap without irq enable on counter 3
        wr(8'h03, 32'hF, "R9 clear all");
        wr(8'h13, 32'h0000_0121, "R9 cfg3");   // en only, cat 2, enc 1
        for (int k = 0; k < 256; k++) ev(4'd2, 16'h0001, 0, 0, 0, 0, 0, "R9 run");
        expect_reg(8'h03, 64'h8, "R9 status no irq");
        n_cmp++;
        if (irq !== 1'b0) begin n_bad++; $display("FAIL R9 irq got %0b exp 0", irq); end

        // R6 reset commands
        wr(8'h02, 32'h1, "R6 freeze before reset");
        wr(8'h01, 32'h2, "R6 zero data");
        expect_reg(8'h20, 64'd0, "R6 data zeroed");
        expect_reg(8'h10, 64'h0531, "R6 cfg kept");
        wr(8'h01, 32'h1, "R6 cfg reset");
        expect_reg(8'h10, 64'h0, "R6 cfg cleared");
        expect_reg(8'h48, 64'h0, "R6 filter cleared");
        expect_reg(8'h03, 64'h0, "R6 status cleared");
        expect_reg(8'h02, 64'h0, "R6 freeze cleared");
        rd(8'h21, "R6 final");

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule